// File: doc/BRIEF.md
# IDE I/O Window Router

This block sits between a host I/O port and the register models of a two-channel disk controller. Each I/O read or write is compared against five windows, each set by a base address and a size. The windows are: the primary command block, the primary control block, the secondary command block, the secondary control block, and the bus-master register block. A matching access goes to the proper target with a window-relative offset. If the access matches nothing, or if its size is illegal, it is reported as a fault.

Each channel remembers which of its two drives is currently addressed, master or slave. It learns this by watching writes to the drive-select register of its command block. Drive accesses go only to that drive. Four strap inputs say which drives are fitted. When the selected drive is not fitted, a byte read returns zero, a byte write is dropped, and a wider access is a fault. Two enable inputs control the rest. When the I/O enable is low, every access is acknowledged and does nothing. When the bus-master enable is low, writes to the bus-master block are dropped.

Every accepted request gets exactly one response, one cycle later. A small response-phase state register holds one of six states: `RSP_IDLE`, `RSP_DRIVE`, `RSP_ZERO`, `RSP_BUS`, `RSP_NOOP` and `RSP_FAULT`. On each clock edge it moves to the class of the request presented in that cycle, or to `RSP_IDLE` when no request is presented. That state chooses the response data and flag: drive read data, bus-master read data, zero, or a fault.

Top module: `ide_io_router`

## Requirements
- R1: After reset there is no response pending (`resp_valid`=0), both channels have the master drive selected (`drv_slave`=2'b00), and the window bases hold their parameter defaults.
- R2: An address hits a window when base <= addr < base + size. If windows overlap, the first match in this order wins: primary command, primary control, secondary command, secondary control, bus-master. A hit drives exactly one target strobe, with `tgt_offset` = addr - base.
- R3: In the primary command window the relative offset is shifted right by `PRI_CMD_SHIFT` (default 2). In the primary control window `PRI_CTRL_ADD` (default 2) is added to it. The secondary windows pass the relative offset unchanged.
- R4: A write to command-window offset 6 selects the slave drive of that channel when data bit 4 (0x10) is 1, and the master drive when it is 0. The same write is routed to the newly selected drive, and the choice persists for later accesses.
- R5: If the selected drive is not fitted (`drive_present` bit index = channel*2 + slave), no drive strobe is raised. A 1-byte access then completes with read data 0 and no fault, and any wider access completes with `resp_err`=1.
- R6: While `io_en`=0, a legal-size access raises no target strobe, changes no drive selection, and completes with `resp_err`=0 and `resp_rdata`=0.
- R7: Only sizes 1, 2 and 4 bytes are legal. Any other size completes with `resp_err`=1, whatever the enables are.
- R8: An access that hits no window completes with `resp_err`=1 and raises no strobe.
- R9: In the bus-master window, relative offsets 0..7 go to channel 0 and offsets 8 and up go to channel 1 with 8 subtracted. While `bm_en`=0, writes to this window are dropped (no strobe, no fault), and reads still go through.
- R10: A base update (`bar_wr_en`, `bar_wr_sel` 0..4 in the R2 order) takes effect from the next cycle, and only when the written value is nonzero.
- R11: `resp_valid` is high exactly in the cycle after each request. For routed reads, `resp_rdata` is the data the addressed target returns in that cycle. For writes it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master write enable |
| drive_present | input | 4 | Fitted-drive straps, bit = channel*2 + slave |
| bar_wr_en | input | 1 | Base update strobe |
| bar_wr_sel | input | 3 | Window to update, 0..4 |
| bar_wr_data | input | AW | New base value |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write |
| req_addr | input | AW | I/O address |
| req_size | input | 3 | Size in bytes |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response strobe, cycle after the request |
| resp_err | output | 1 | Fault response |
| resp_rdata | output | 32 | Read data |
| drv_valid | output | 2 | Per-channel drive request strobe |
| drv_slave | output | 2 | Per-channel drive addressed (1 = slave) |
| drv_ctrl | output | 1 | 1 = control block, 0 = command block |
| tgt_write | output | 1 | Target write flag |
| tgt_offset | output | AW | Window-relative offset |
| tgt_size | output | 3 | Target access size |
| tgt_wdata | output | 32 | Target write data |
| drv_rdata | input | 64 | Per-channel drive read data, channel 1 in the upper half |
| bmi_valid | output | 1 | Bus-master register request strobe |
| bmi_chan | output | 1 | Bus-master channel |
| bmi_rdata | input | 32 | Bus-master read data |

## Verification
Most internal faults in this block show up at the ports within one access.

- A wrong drive-selection bit shows on `drv_slave` in the same cycle as the next access to that channel. The read data one cycle later, which carries the drive identity, shows it too.
- A stale or wrongly accepted base moves the hit boundary. An address just inside or just outside a window then lands on the wrong strobe, or gets a wrong fault flag, in the very next response.
- A mis-registered response-phase state appears directly as the wrong mix of `resp_valid`, `resp_err` and `resp_rdata` one cycle after the request.

The random traffic targets window edges, odd sizes and drive-select writes, so each of these faults is reached within a few transactions.

// File: rtl/ide_rt_pkg.sv
package ide_rt_pkg;

    localparam int NWIN = 5;
    localparam int NCH  = 2;
    localparam int DW   = 32;

    // Window index; the numeric order is the match priority.
    typedef enum logic [2:0] {
        WIN_PCMD = 3'd0,
        WIN_PCTL = 3'd1,
        WIN_SCMD = 3'd2,
        WIN_SCTL = 3'd3,
        WIN_BUS  = 3'd4
    } win_e;

    // Class of the response presented in the cycle after a request.
    typedef enum logic [2:0] {
        RSP_IDLE  = 3'd0,
        RSP_DRIVE = 3'd1,
        RSP_ZERO  = 3'd2,
        RSP_BUS   = 3'd3,
        RSP_NOOP  = 3'd4,
        RSP_FAULT = 3'd5
    } rsp_e;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/ide_rt_base_regs.sv
module ide_rt_base_regs #(
    parameter int AW = 16,
    parameter logic [ide_rt_pkg::NWIN*AW-1:0] RST_BASE = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_sel,
    input  logic [AW-1:0]                 wr_data,
    output logic [ide_rt_pkg::NWIN*AW-1:0] bases
);
    import ide_rt_pkg::*;

    // A zero value never replaces a programmed base.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bases <= RST_BASE;
        end else if (wr_en && (wr_data != '0)) begin
            for (int i = 0; i < NWIN; i++) begin
                if (wr_sel == 3'(i)) begin
                    bases[i*AW +: AW] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/ide_rt_win_match.sv
module ide_rt_win_match #(
    parameter int AW = 16,
    parameter logic [ide_rt_pkg::NWIN*AW-1:0] WIN_SIZE = '0
) (
    input  logic [AW-1:0]                  addr,
    input  logic [ide_rt_pkg::NWIN*AW-1:0] bases,
    output logic                           hit_any,
    output ide_rt_pkg::win_e               hit_win,
    output logic [AW-1:0]                  hit_rel
);
    import ide_rt_pkg::*;

    logic [NWIN-1:0] hit;
    logic [AW-1:0]   rel [NWIN];

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        logic [AW:0] lo;
        logic [AW:0] hi;
        assign lo     = {1'b0, bases[i*AW +: AW]};
        assign hi     = lo + {1'b0, WIN_SIZE[i*AW +: AW]};
        assign hit[i] = ({1'b0, addr} >= lo) && ({1'b0, addr} < hi);
        assign rel[i] = addr - bases[i*AW +: AW];
    end

    // Scan from the lowest priority up so the first window in order wins.
    always_comb begin
        hit_any = 1'b0;
        hit_win = WIN_PCMD;
        hit_rel = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                hit_any = 1'b1;
                hit_win = win_e'(i);
                hit_rel = rel[i];
            end
        end
    end

endmodule

// File: rtl/ide_rt_drive_sel.sv
module ide_rt_drive_sel #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd_en,
    input  logic           upd_ch,
    input  logic           upd_slave,
    output logic [NCH-1:0] sel_q
);

    // Master is selected on every channel out of reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (upd_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (upd_ch == 1'(c)) begin
                    sel_q[c] <= upd_slave;
                end
            end
        end
    end

endmodule

// File: rtl/ide_io_router.sv
module ide_io_router #(
    parameter int AW            = 16,
    parameter int PRI_CMD_SHIFT = 2,
    parameter int PRI_CTRL_ADD  = 2,
    parameter int BMI_SPAN      = 8,
    parameter int SEL_OFS       = 6,
    parameter int SEL_BIT       = 4,
    parameter logic [ide_rt_pkg::NWIN*AW-1:0] RST_BASE =
        {16'h01C0, 16'h0178, 16'h0170, 16'h0140, 16'h0100},
    parameter logic [ide_rt_pkg::NWIN*AW-1:0] WIN_SIZE =
        {16'd16, 16'd4, 16'd8, 16'd4, 16'd32}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_en,
    input  logic          bm_en,
    input  logic [3:0]    drive_present,
    input  logic          bar_wr_en,
    input  logic [2:0]    bar_wr_sel,
    input  logic [AW-1:0] bar_wr_data,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [31:0]   req_wdata,
    output logic          resp_valid,
    output logic          resp_err,
    output logic [31:0]   resp_rdata,
    output logic [1:0]    drv_valid,
    output logic [1:0]    drv_slave,
    output logic          drv_ctrl,
    output logic          tgt_write,
    output logic [AW-1:0] tgt_offset,
    output logic [2:0]    tgt_size,
    output logic [31:0]   tgt_wdata,
    input  logic [63:0]   drv_rdata,
    output logic          bmi_valid,
    output logic          bmi_chan,
    input  logic [31:0]   bmi_rdata
);
    import ide_rt_pkg::*;

    localparam logic [AW-1:0] SEL_OFS_V = AW'(SEL_OFS);
    localparam logic [AW-1:0] CTRL_ADD  = AW'(PRI_CTRL_ADD);
    localparam logic [AW-1:0] BMI_SPANV = AW'(BMI_SPAN);

    logic [NWIN*AW-1:0] bases;
    logic               hit_any;
    win_e               hit_win;
    logic [AW-1:0]      hit_rel;
    logic [NCH-1:0]     sel_q;

    logic sel_upd;
    logic sel_upd_ch;
    logic sel_upd_val;

    rsp_e rsp_q, rsp_d;
    logic rsp_ch_q, rsp_ch_d;
    logic rsp_rd_q;

    logic win_ch;
    logic is_ctrl;
    logic eff_slave;

    ide_rt_base_regs #(.AW(AW), .RST_BASE(RST_BASE)) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bar_wr_en),
        .wr_sel  (bar_wr_sel),
        .wr_data (bar_wr_data),
        .bases   (bases)
    );

    ide_rt_win_match #(.AW(AW), .WIN_SIZE(WIN_SIZE)) u_match (
        .addr    (req_addr),
        .bases   (bases),
        .hit_any (hit_any),
        .hit_win (hit_win),
        .hit_rel (hit_rel)
    );

    ide_rt_drive_sel #(.NCH(NCH)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (sel_upd),
        .upd_ch    (sel_upd_ch),
        .upd_slave (sel_upd_val),
        .sel_q     (sel_q)
    );

    assign tgt_write = req_write;
    assign tgt_size  = req_size;
    assign tgt_wdata = req_wdata;

    // Request classification: target strobes and next response state.
    always_comb begin
        rsp_d       = RSP_IDLE;
        rsp_ch_d    = 1'b0;
        drv_valid   = '0;
        drv_slave   = sel_q;
        drv_ctrl    = 1'b0;
        bmi_valid   = 1'b0;
        bmi_chan    = 1'b0;
        tgt_offset  = hit_rel;
        sel_upd     = 1'b0;
        sel_upd_ch  = 1'b0;
        sel_upd_val = 1'b0;
        win_ch      = (hit_win == WIN_SCMD) || (hit_win == WIN_SCTL);
        is_ctrl     = (hit_win == WIN_PCTL) || (hit_win == WIN_SCTL);
        eff_slave   = sel_q[win_ch];
        if (req_valid) begin
            if (!size_legal(req_size)) begin
                rsp_d = RSP_FAULT;
            end else if (!io_en) begin
                rsp_d = RSP_NOOP;
            end else if (!hit_any) begin
                rsp_d = RSP_FAULT;
            end else begin
                unique case (hit_win)
                    WIN_PCMD, WIN_PCTL, WIN_SCMD, WIN_SCTL: begin
                        if (hit_win == WIN_PCMD) begin
                            tgt_offset = hit_rel >> PRI_CMD_SHIFT;
                        end else if (hit_win == WIN_PCTL) begin
                            tgt_offset = hit_rel + CTRL_ADD;
                        end
                        if (!is_ctrl && req_write && (tgt_offset == SEL_OFS_V)) begin
                            sel_upd     = 1'b1;
                            sel_upd_ch  = win_ch;
                            sel_upd_val = req_wdata[SEL_BIT];
                            eff_slave   = req_wdata[SEL_BIT];
                        end
                        drv_slave[win_ch] = eff_slave;
                        drv_ctrl          = is_ctrl;
                        rsp_ch_d          = win_ch;
                        if (drive_present[{win_ch, eff_slave}]) begin
                            drv_valid[win_ch] = 1'b1;
                            rsp_d             = RSP_DRIVE;
                        end else if (req_size == 3'd1) begin
                            rsp_d = RSP_ZERO;
                        end else begin
                            rsp_d = RSP_FAULT;
                        end
                    end
                    WIN_BUS: begin
                        if (req_write && !bm_en) begin
                            rsp_d = RSP_NOOP;
                        end else begin
                            bmi_valid = 1'b1;
                            if (hit_rel >= BMI_SPANV) begin
                                bmi_chan   = 1'b1;
                                tgt_offset = hit_rel - BMI_SPANV;
                            end
                            rsp_ch_d = bmi_chan;
                            rsp_d    = RSP_BUS;
                        end
                    end
                    default: rsp_d = RSP_FAULT;
                endcase
            end
        end
    end

    // Response-phase state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q    <= RSP_IDLE;
            rsp_ch_q <= 1'b0;
            rsp_rd_q <= 1'b0;
        end else begin
            rsp_q    <= rsp_d;
            rsp_ch_q <= rsp_ch_d;
            rsp_rd_q <= !req_write;
        end
    end

    // Response outputs decoded from the registered state.
    always_comb begin
        resp_valid = 1'b0;
        resp_err   = 1'b0;
        resp_rdata = '0;
        unique case (rsp_q)
            RSP_IDLE: ;
            RSP_DRIVE: begin
                resp_valid = 1'b1;
                if (rsp_rd_q) begin
                    resp_rdata = rsp_ch_q ? drv_rdata[63:32] : drv_rdata[31:0];
                end
            end
            RSP_BUS: begin
                resp_valid = 1'b1;
                if (rsp_rd_q) begin
                    resp_rdata = bmi_rdata;
                end
            end
            RSP_ZERO, RSP_NOOP: resp_valid = 1'b1;
            RSP_FAULT: begin
                resp_valid = 1'b1;
                resp_err   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ide_io_router_chk.sv
module ide_io_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_en,
    input logic       bm_en,
    input logic [3:0] drive_present,
    input logic       req_valid,
    input logic [2:0] req_size,
    input logic       resp_valid,
    input logic       resp_err,
    input logic [31:0] resp_rdata,
    input logic [1:0] drv_valid,
    input logic [1:0] drv_slave,
    input logic       tgt_write,
    input logic       bmi_valid
);
    import ide_rt_pkg::*;

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drv_valid, bmi_valid}));

    // R5
    ch0_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid[0] |-> drive_present[{1'b0, drv_slave[0]}]);

    // R5
    ch1_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid[1] |-> drive_present[{1'b1, drv_slave[1]}]);

    // R6
    io_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en) |-> (drv_valid == 2'b00) && !bmi_valid);

    // R6
    io_off_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en && size_legal(req_size)) |=>
            (resp_valid && !resp_err && (resp_rdata == 32'd0)));

    // R7
    bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !size_legal(req_size)) |=> (resp_valid && resp_err));

    // R9
    bm_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bmi_valid && tgt_write) |-> bm_en);

    // R11
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

endmodule

bind ide_io_router ide_io_router_chk chk_i (.*);

// File: tb/ide_io_router_tb_top.sv
module ide_io_router_tb_top;

    localparam int K_DRV = 1, K_ZERO = 2, K_BUS = 3, K_NOOP = 4, K_FAULT = 5;
    localparam logic [3:0] PRESENT = 4'b0111; // secondary slave absent

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_en = 1'b1, bm_en = 1'b1;
    logic bar_wr_en = 1'b0;
    logic [2:0] bar_wr_sel = '0;
    logic [15:0] bar_wr_data = '0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0] req_size = 3'd1;
    logic [31:0] req_wdata = '0;
    logic resp_valid, resp_err;
    logic [31:0] resp_rdata;
    logic [1:0] drv_valid, drv_slave;
    logic drv_ctrl, tgt_write, bmi_valid, bmi_chan;
    logic [15:0] tgt_offset;
    logic [2:0] tgt_size;
    logic [31:0] tgt_wdata;
    logic [31:0] m_rd0 = '0, m_rd1 = '0, m_bmi = '0;

    int n_tests = 0, n_fail = 0;
    logic [15:0] base [5];
    int wsz [5];
    logic msel [2];

    always #5 clk = ~clk;

    ide_io_router dut_i (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
        .drive_present(PRESENT), .bar_wr_en(bar_wr_en), .bar_wr_sel(bar_wr_sel),
        .bar_wr_data(bar_wr_data), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .drv_valid(drv_valid), .drv_slave(drv_slave), .drv_ctrl(drv_ctrl),
        .tgt_write(tgt_write), .tgt_offset(tgt_offset), .tgt_size(tgt_size),
        .tgt_wdata(tgt_wdata), .drv_rdata({m_rd1, m_rd0}), .bmi_valid(bmi_valid),
        .bmi_chan(bmi_chan), .bmi_rdata(m_bmi)
    );

    // Target models: identity-tagged read data, one cycle after the strobe.
    always @(posedge clk) begin
        if (drv_valid[0]) m_rd0 <= {8'd0, 7'd0, drv_slave[0], 7'd0, drv_ctrl, tgt_offset[7:0]};
        if (drv_valid[1]) m_rd1 <= {8'd1, 7'd0, drv_slave[1], 7'd0, drv_ctrl, tgt_offset[7:0]};
        if (bmi_valid)    m_bmi <= {8'hB0, 7'd0, bmi_chan, tgt_offset};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bar_write(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        bar_wr_en = 1'b1; bar_wr_sel = sel; bar_wr_data = val;
        @(negedge clk);
        bar_wr_en = 1'b0;
        if (val != 16'd0 && sel < 3'd5) base[sel] = val;
    endtask

    function automatic bit legal(input logic [2:0] s);
        return s == 3'd1 || s == 3'd2 || s == 3'd4;
    endfunction

    task automatic txn(input bit wr, input logic [15:0] a, input logic [2:0] sz,
                       input logic [31:0] wd, input string tag);
        int w = -1, rel = 0, kind, ch = 0, off = 0;
        bit ctrl = 0, eff = 0, bch = 0;
        logic [1:0] exp_dv = 2'b00;
        logic [31:0] exp_rd = 32'd0;
        for (int i = 0; i < 5; i++)
            if (w < 0 && int'(a) >= int'(base[i]) && int'(a) < int'(base[i]) + wsz[i]) w = i;
        if (w >= 0) rel = int'(a) - int'(base[w]);
        if (!legal(sz)) kind = K_FAULT;
        else if (!io_en) kind = K_NOOP;
        else if (w < 0) kind = K_FAULT;
        else if (w == 4) begin
            if (wr && !bm_en) kind = K_NOOP;
            else begin
                kind = K_BUS; bch = (rel >= 8); off = bch ? rel - 8 : rel;
            end
        end else begin
            ch = (w == 2 || w == 3) ? 1 : 0;
            ctrl = (w == 1 || w == 3);
            off = (w == 0) ? (rel >> 2) : (w == 1) ? rel + 2 : rel;
            eff = msel[ch];
            if (!ctrl && wr && off == 6) eff = wd[4];
            msel[ch] = eff;
            if (PRESENT[ch*2 + int'(eff)]) begin
                kind = K_DRV; exp_dv[ch] = 1'b1;
            end else kind = (sz == 3'd1) ? K_ZERO : K_FAULT;
        end
        if (!wr && kind == K_DRV) exp_rd = {8'(ch), 7'd0, eff, 7'd0, ctrl, 8'(off)};
        if (!wr && kind == K_BUS) exp_rd = {8'hB0, 7'd0, bch, 16'(off)};

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        #1;
        chk(drv_valid == exp_dv, tag, "drv_valid", 32'(drv_valid), 32'(exp_dv));
        chk(bmi_valid == (kind == K_BUS), tag, "bmi_valid", 32'(bmi_valid), 32'(kind == K_BUS));
        if (kind == K_DRV) begin
            chk(drv_slave[ch] == eff, tag, "drv_slave", 32'(drv_slave[ch]), 32'(eff));
            chk(drv_ctrl == ctrl, tag, "drv_ctrl", 32'(drv_ctrl), 32'(ctrl));
            chk(tgt_offset == 16'(off), tag, "offset", 32'(tgt_offset), 32'(off));
        end
        if (kind == K_BUS) begin
            chk(bmi_chan == bch, tag, "bmi_chan", 32'(bmi_chan), 32'(bch));
            chk(tgt_offset == 16'(off), tag, "bmi offset", 32'(tgt_offset), 32'(off));
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(resp_valid == 1'b1, tag, "resp_valid", 32'(resp_valid), 32'd1);
        chk(resp_err == (kind == K_FAULT), tag, "resp_err", 32'(resp_err), 32'(kind == K_FAULT));
        chk(resp_rdata == exp_rd, tag, "resp_rdata", resp_rdata, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd24681;
        void'($urandom(seed));
        base[0] = 16'h0100; base[1] = 16'h0140; base[2] = 16'h0170;
        base[3] = 16'h0178; base[4] = 16'h01C0;
        wsz[0] = 32; wsz[1] = 4; wsz[2] = 8; wsz[3] = 4; wsz[4] = 16;
        msel[0] = 1'b0; msel[1] = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drv_slave == 2'b00, "R1", "master selected", 32'(drv_slave), 32'd0);
        chk(resp_valid == 1'b0, "R1", "no response", 32'(resp_valid), 32'd0);
        txn(0, 16'h0170, 3'd1, 0, "R1 default base");
        // R2 / R11 basic routing
        txn(0, 16'h0100, 3'd1, 0, "R2 R11 pcmd read");
        txn(0, 16'h017B, 3'd2, 0, "R2 sctl last byte");
        // R3 offsets
        txn(0, 16'h0108, 3'd1, 0, "R3 shift");
        txn(0, 16'h0141, 3'd1, 0, "R3 ctrl add");
        txn(1, 16'h0142, 3'd1, 32'h5A, "R3 ctrl write");
        // R4 selection
        txn(1, 16'h0118, 3'd1, 32'h10, "R4 select slave");
        txn(0, 16'h0104, 3'd2, 0, "R4 slave persists");
        chk(drv_slave[0] == 1'b1, "R4", "sel kept", 32'(drv_slave[0]), 32'd1);
        txn(1, 16'h0118, 3'd1, 32'hEF, "R4 select master");
        // R5 absent secondary slave
        txn(1, 16'h0176, 3'd1, 32'h10, "R5 select absent");
        txn(0, 16'h0170, 3'd1, 0, "R5 zero read");
        txn(0, 16'h0179, 3'd1, 0, "R5 ctrl zero read");
        txn(0, 16'h0170, 3'd2, 0, "R5 wide fault");
        txn(1, 16'h0176, 3'd1, 32'h00, "R5 reselect master");
        // R6 io disabled
        io_en = 1'b0;
        txn(0, 16'h0100, 3'd1, 0, "R6 read noop");
        txn(1, 16'h0118, 3'd1, 32'h10, "R6 write noop");
        io_en = 1'b1;
        txn(0, 16'h0100, 3'd1, 0, "R6 select unchanged");
        // R7 sizes
        txn(0, 16'h0100, 3'd3, 0, "R7 size3");
        txn(0, 16'h0100, 3'd0, 0, "R7 size0");
        io_en = 1'b0;
        txn(0, 16'h0100, 3'd5, 0, "R7 size5 io off");
        io_en = 1'b1;
        txn(0, 16'h0100, 3'd4, 0, "R7 size4");
        // R8 miss and edges
        txn(0, 16'h0000, 3'd1, 0, "R8 miss");
        txn(0, 16'h0120, 3'd1, 0, "R8 end edge");
        txn(0, 16'h00FF, 3'd1, 0, "R8 below base");
        txn(0, 16'h01D0, 3'd1, 0, "R8 past bus window");
        // R9 bus-master window
        txn(0, 16'h01C2, 3'd1, 0, "R9 chan0");
        txn(0, 16'h01CA, 3'd2, 0, "R9 chan1");
        bm_en = 1'b0;
        txn(1, 16'h01C0, 3'd1, 32'h1, "R9 write gated");
        txn(0, 16'h01CC, 3'd4, 0, "R9 read ungated");
        bm_en = 1'b1;
        txn(1, 16'h01C8, 3'd1, 32'h1, "R9 write open");
        // R10 base updates and R2 priority
        bar_write(3'd2, 16'h0000);
        txn(0, 16'h0170, 3'd1, 0, "R10 zero ignored");
        bar_write(3'd2, 16'h0100);
        txn(0, 16'h0104, 3'd1, 0, "R2 priority overlap");
        bar_write(3'd2, 16'h0180);
        txn(0, 16'h0180, 3'd1, 0, "R10 moved base");
        txn(0, 16'h0170, 3'd1, 0, "R10 old base");
        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int pick = int'($urandom % 6);
            int r = int'($urandom % 8);
            logic [15:0] a;
            logic [2:0] sz;
            logic [31:0] wd = $urandom;
            if (pick < 5) a = base[pick] + 16'($urandom % (wsz[pick] + 2));
            else a = 16'($urandom % 16'h0200);
            if (($urandom % 3) == 0) begin
                a = (pick == 2) ? base[2] + 16'd6 : base[0] + 16'd24;
                wd[4] = 1'($urandom);
            end
            sz = (r < 3) ? 3'd1 : (r < 5) ? 3'd2 : (r < 7) ? 3'd4 : 3'(($urandom % 2) * 3);
            io_en = (($urandom % 10) != 0);
            bm_en = 1'($urandom);
            txn(1'($urandom), a, sz, wd, "R2 R4 R5 R9 R11 random");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule